// File: doc/BRIEF.md
# Pre-decoded Multi-Pattern Byte Stream Matcher

This block scans a byte stream, one byte per clock when a valid flag is high. It raises one output bit per pattern in the cycle that reports a fixed pattern ending on the latest valid byte. The pattern set is built in at elaboration time. The default set has six patterns: `/cgi-win`, `/cgi-bin`, `/scripts`, `/unsafe.cgi`, `/insecure.cgi` and `safe.cgi`.

A single decoder at the front turns each byte into one-hot character lines. There is one line for each character value that some pattern uses, and the decoder output is registered. Each line then enters a shift chain that advances only on valid bytes. A pattern test never compares 8-bit values. It picks one bit from each chain at a depth set by the character's distance from the pattern's end, and ANDs those bits together.

These terms are ANDed in groups of four into registered chunk bits, and the match is the AND of a pattern's chunk bits. Patterns that begin with the same characters share one prefix term. That term is computed once, delayed in its own chain, and ANDed with each pattern's remaining characters. The patterns are split into two lanes, and each lane keeps chains only for the characters its own patterns use.

Top module: `smatch_top`

## Requirements
- R1: Output bit order is fixed: bit 0 `/cgi-win`, bit 1 `/cgi-bin`, bit 2 `/scripts`, bit 3 `/unsafe.cgi`, bit 4 `/insecure.cgi`, bit 5 `safe.cgi`. A bit rises when the latest valid bytes spell its pattern exactly.
- R2: Suppose the final byte of a pattern is sampled at clock edge k. The pattern's bit is then high from edge k+2 until edge k+3, and low again after that unless another occurrence ends.
- R3: Cycles with `byte_vld` low neither advance nor disturb the stream history. A pattern whose bytes are separated by such cycles still matches.
- R4: No output bit is ever raised for a cycle whose byte had `byte_vld` low, whatever its value.
- R5: Back-to-back occurrences of a pattern each produce their own one-cycle pulse.
- R6: Several bits may rise in the same cycle. A stream ending in `/unsafe.cgi` raises bits 3 and 5 together.
- R7: Patterns that share a leading part are told apart by their remaining characters only. `/cgi-bin` raises bit 1 and not bit 0, and mixed tails such as `/cgi-wib` raise neither bit.
- R8: While `rst_n` is low, every output is 0 and all history is cleared. Bytes received before a reset never combine with bytes received after it.
- R9: Matching is exact and case sensitive. A sequence differing from a pattern in any single byte, including its first or last byte or its letter case, raises no bit.
- R10: On a long stream of random bytes and random valid gaps, with patterns planted in it, the outputs equal a direct search of the valid-byte history on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| byte_vld | input | 1 | High when `byte_in` carries a stream byte |
| byte_in | input | 8 | Stream byte |
| match | output | 6 | One pulse bit per pattern, order as in R1 |

## Verification
Some rules hold on every cycle, and the bound checker enforces them directly:
- no bit rises unless the byte two edges earlier was valid;
- no bit rises before enough valid bytes have arrived since reset to form the shortest pattern;
- `/unsafe.cgi` never fires without `safe.cgi`, and the two `/cgi-` patterns never fire together;
- the outputs are never unknown.

Other behaviour depends on particular byte sequences, and only the bench scenarios show it: the exact two-edge latency and single-cycle pulse width, matches that survive idle gaps, back-to-back repeats, near-miss rejection, loss of partial history across a reset, and agreement with a reference search over a long random stream.

// File: rtl/smatch_pkg.sv
package smatch_pkg;
  localparam int CHAR_W     = 8;
  localparam int NCHAR      = 1 << CHAR_W;
  localparam int MAX_LEN    = 16;
  localparam int CHUNK      = 4;
  localparam int NPAT       = 6;
  localparam int NLANE      = 2;
  localparam int NPRE       = 1;

  typedef logic [MAX_LEN*CHAR_W-1:0] str_t;
  typedef logic [NCHAR-1:0]          line_t;

  // Patterns are right-aligned: the last character sits in the low byte.
  localparam str_t PAT_STR [NPAT] = '{
    str_t'("/cgi-win"), str_t'("/cgi-bin"), str_t'("/scripts"),
    str_t'("/unsafe.cgi"), str_t'("/insecure.cgi"), str_t'("safe.cgi")};
  localparam int PAT_LEN  [NPAT] = '{8, 8, 8, 11, 13, 8};
  localparam int PAT_LANE [NPAT] = '{0, 0, 0, 1, 1, 1};
  localparam int PAT_PRE  [NPAT] = '{0, 0, -1, -1, -1, -1};

  localparam str_t PRE_STR  [NPRE] = '{str_t'("/cgi-")};
  localparam int   PRE_LEN  [NPRE] = '{5};
  localparam int   PRE_LANE [NPRE] = '{0};

  function automatic logic [CHAR_W-1:0] str_char(str_t s, int len, int i);
    return s[(len-1-i)*CHAR_W +: CHAR_W];
  endfunction

  function automatic logic [CHAR_W-1:0] pat_char(int p, int i);
    return str_char(PAT_STR[p], PAT_LEN[p], i);
  endfunction

  function automatic line_t lane_mask(int lane);
    line_t m;
    m = '0;
    for (int p = 0; p < NPAT; p++)
      if (PAT_LANE[p] == lane)
        for (int i = 0; i < MAX_LEN; i++)
          if (i < PAT_LEN[p]) m[pat_char(p, i)] = 1'b1;
    return m;
  endfunction

  function automatic line_t used_mask();
    line_t m;
    m = '0;
    for (int l = 0; l < NLANE; l++) m |= lane_mask(l);
    return m;
  endfunction

  function automatic int lane_depth(int lane);
    int d;
    d = 3;
    for (int p = 0; p < NPAT; p++)
      if (PAT_LANE[p] == lane && PAT_LEN[p] > d) d = PAT_LEN[p];
    return d;
  endfunction

  function automatic int pre_len(int p);
    return (PAT_PRE[p] < 0) ? 0 : PRE_LEN[PAT_PRE[p]];
  endfunction

  function automatic int term_count(int p);
    return PAT_LEN[p] - pre_len(p) + ((PAT_PRE[p] < 0) ? 0 : 1);
  endfunction

  function automatic int min_len();
    int m;
    m = MAX_LEN;
    for (int p = 0; p < NPAT; p++) if (PAT_LEN[p] < m) m = PAT_LEN[p];
    return m;
  endfunction
endpackage

// File: rtl/smatch_decode.sv
module smatch_decode
  import smatch_pkg::*;
#(
  parameter line_t MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [CHAR_W-1:0] in_byte,
  output line_t             dec_line,
  output logic              dec_vld
);
  line_t line_d;

  always_comb begin
    line_d = '0;
    for (int c = 0; c < NCHAR; c++)
      if (MASK[c]) line_d[c] = in_vld && (in_byte == CHAR_W'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_line <= '0;
      dec_vld  <= 1'b0;
    end else begin
      dec_line <= line_d;
      dec_vld  <= in_vld;
    end
  end
endmodule

// File: rtl/smatch_tap.sv
module smatch_tap #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             d,
  output logic [DEPTH-1:0] taps
);
  logic [DEPTH-1:1] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en) sr_d = {sr_q[DEPTH-2:1], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign taps = {sr_q, d};
endmodule

// File: rtl/smatch_lane.sv
module smatch_lane
  import smatch_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  line_t           dec_line,
  input  logic            dec_vld,
  output logic [NPAT-1:0] hit
);
  localparam line_t MASK  = lane_mask(LANE);
  localparam int    DEPTH = lane_depth(LANE);

  logic [DEPTH-1:0] tap     [NCHAR];
  logic [DEPTH-1:0] pre_tap [NPRE];

  for (genvar c = 0; c < NCHAR; c++) begin : g_chr
    if (MASK[c]) begin : g_on
      smatch_tap #(.DEPTH(DEPTH)) u_tap (
        .clk(clk), .rst_n(rst_n), .en(dec_vld), .d(dec_line[c]), .taps(tap[c]));
    end else begin : g_off
      assign tap[c] = '0;
    end
  end

  for (genvar q = 0; q < NPRE; q++) begin : g_pre
    if (PRE_LANE[q] == LANE) begin : g_on
      logic pre_hit;
      always_comb begin
        pre_hit = dec_vld;
        for (int i = 0; i < MAX_LEN; i++)
          if (i < PRE_LEN[q])
            pre_hit &= tap[str_char(PRE_STR[q], PRE_LEN[q], i)][PRE_LEN[q]-1-i];
      end
      smatch_tap #(.DEPTH(DEPTH)) u_ptap (
        .clk(clk), .rst_n(rst_n), .en(dec_vld), .d(pre_hit), .taps(pre_tap[q]));
    end else begin : g_off
      assign pre_tap[q] = '0;
    end
  end

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    if (PAT_LANE[p] == LANE) begin : g_on
      localparam int PL  = pre_len(p);
      localparam int OFF = (PL > 0) ? 1 : 0;
      localparam int PQ  = (PAT_PRE[p] < 0) ? 0 : PAT_PRE[p];
      localparam int NT  = term_count(p);
      localparam int NCH = (NT + CHUNK - 1) / CHUNK;

      logic [NCH*CHUNK-1:0] term;
      logic [NCH-1:0]       chunk_d, chunk_q;

      always_comb begin
        term = '1;
        if (PL > 0) term[0] = pre_tap[PQ][PAT_LEN[p]-PL];
        for (int i = 0; i < MAX_LEN; i++)
          if (i >= PL && i < PAT_LEN[p])
            term[i-PL+OFF] = tap[pat_char(p, i)][PAT_LEN[p]-1-i];
      end

      always_comb begin
        for (int k = 0; k < NCH; k++)
          chunk_d[k] = dec_vld & (&term[k*CHUNK +: CHUNK]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chunk_q <= '0;
        else        chunk_q <= chunk_d;
      end

      assign hit[p] = &chunk_q;
    end else begin : g_off
      assign hit[p] = 1'b0;
    end
  end

  logic unused_fold;
  always_comb begin
    unused_fold = ^(dec_line & ~MASK);
    for (int c = 0; c < NCHAR; c++) unused_fold ^= ^tap[c];
    for (int q = 0; q < NPRE; q++)  unused_fold ^= ^pre_tap[q];
  end
endmodule

// File: rtl/smatch_top.sv
module smatch_top
  import smatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [CHAR_W-1:0] byte_in,
  output logic [NPAT-1:0]   match
);
  line_t           dec_line;
  logic            dec_vld;
  logic [NPAT-1:0] lane_hit [NLANE];

  smatch_decode #(.MASK(used_mask())) u_dec (
    .clk(clk), .rst_n(rst_n), .in_vld(byte_vld), .in_byte(byte_in),
    .dec_line(dec_line), .dec_vld(dec_vld));

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    smatch_lane #(.LANE(l)) u_lane (
      .clk(clk), .rst_n(rst_n), .dec_line(dec_line), .dec_vld(dec_vld),
      .hit(lane_hit[l]));
  end

  always_comb begin
    match = '0;
    for (int l = 0; l < NLANE; l++) match |= lane_hit[l];
  end
endmodule

// File: rtl/smatch_chk.sv
module smatch_chk
  import smatch_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            byte_vld,
  input logic [NPAT-1:0] match
);
  localparam int MINL  = min_len();
  localparam int CNT_W = $clog2(MAX_LEN + 1) + 1;

  logic [CNT_W-1:0] vcnt_q, vcnt_d;

  always_comb begin
    vcnt_d = vcnt_q;
    if (byte_vld && vcnt_q < CNT_W'(MAX_LEN)) vcnt_d = vcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt_q <= '0;
    else        vcnt_q <= vcnt_d;
  end

  AST_HIT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> $past(byte_vld, 2)); // R4
  AST_HIT_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> (vcnt_q >= CNT_W'(MINL))); // R8
  AST_SUFFIX_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    match[3] |-> match[5]); // R6
  AST_SHARED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(match[0] && match[1])); // R7
  AST_NO_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(match)); // R1
endmodule

bind smatch_top smatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .match(match));

// File: tb/smatch_top_bench.sv
module smatch_top_bench;
  logic       clk;
  logic       rst_n;
  logic       byte_vld;
  logic [7:0] byte_in;
  logic [5:0] match;

  typedef struct {
    logic [5:0] vec;
    string      tag;
  } exp_t;

  exp_t       exp_q [$];
  exp_t       mon_item;
  int         total = 0;
  int         bad = 0;
  bit         mon_on = 0;
  bit         done = 0;
  logic [7:0] hist [16];
  string      pats [6] = '{"/cgi-win", "/cgi-bin", "/scripts",
                           "/unsafe.cgi", "/insecure.cgi", "safe.cgi"};
  string      alpha = "/cgi-winbsrptuafe.x";

  smatch_top u_smatch_top (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .match(match));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(logic [5:0] exp, string tag);
    total++;
    if (match !== exp) begin
      bad++;
      $display("FAIL %s: match=%b expected=%b", tag, match, exp);
    end
  endtask

  function automatic logic [5:0] ref_hits();
    logic [5:0] v;
    for (int p = 0; p < 6; p++) begin
      v[p] = 1'b1;
      for (int i = 0; i < pats[p].len(); i++)
        if (hist[pats[p].len()-1-i] != pats[p][i]) v[p] = 1'b0;
    end
    return v;
  endfunction

  // Driver: applies one byte and queues the output expected two edges on.
  task automatic send(logic [7:0] b, bit v, string tag);
    exp_t e;
    @(negedge clk);
    #1;
    byte_in  = b;
    byte_vld = v;
    e.vec = '0;
    if (v) begin
      for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = b;
      e.vec = ref_hits();
    end
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_str(string s, string tag);
    for (int i = 0; i < s.len(); i++) send(s[i], 1'b1, tag);
  endtask

  task automatic do_reset();
    exp_t z;
    mon_on = 0;
    @(negedge clk);
    #1;
    rst_n    = 1'b0;
    byte_vld = 1'b0;
    repeat (3) @(negedge clk);
    check(6'd0, "R8 outputs low in reset");
    for (int i = 0; i < 16; i++) hist[i] = 8'h00;
    exp_q.delete();
    z.vec = '0;
    z.tag = "R2 leading cycle";
    exp_q.push_back(z);
    exp_q.push_back(z);
    #1;
    rst_n  = 1'b1;
    mon_on = 1;
  endtask

  // Monitor: pops one expected item per cycle and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (exp_q.size() == 0) check(6'd0, "R4 idle");
        else begin
          mon_item = exp_q.pop_front();
          check(mon_item.vec, mon_item.tag);
        end
      end
    end
  end

  task automatic run_random();
    int r;
    int p;
    for (int n = 0; n < 3000; n++) begin
      r = $urandom_range(0, 99);
      if (r < 8) begin
        p = $urandom_range(0, 5);
        for (int i = 0; i < pats[p].len(); i++) begin
          if ($urandom_range(0, 3) == 0) send(8'($urandom_range(0, 255)), 1'b0, "R10");
          send(pats[p][i], 1'b1, "R10");
        end
      end else if (r < 75) begin
        send(alpha[$urandom_range(0, alpha.len()-1)], $urandom_range(0, 9) != 0, "R10");
      end else begin
        send(8'($urandom_range(0, 255)), $urandom_range(0, 9) != 0, "R10");
      end
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    byte_vld = 1'b0;
    byte_in  = 8'h00;
    for (int i = 0; i < 16; i++) hist[i] = 8'h00;
    do_reset();

    // R1: every pattern alone with filler around it
    for (int p = 0; p < 6; p++) begin
      send_str("zz", "R1 filler");
      send_str(pats[p], "R1 single pattern");
    end
    // R2: pulse lasts one cycle, then idle
    send_str("/scripts", "R2 latency");
    for (int i = 0; i < 3; i++) send(8'h00, 1'b0, "R2 pulse ends");
    // R3: invalid cycles inside a pattern
    for (int i = 0; i < 13; i++) begin
      send(8'h41, 1'b0, "R3 gap");
      send(pats[4][i], 1'b1, "R3 gapped pattern");
    end
    // R4: completing byte present but not valid
    send_str("/cgi-wi", "R4 setup");
    send("n", 1'b0, "R4 invalid last byte");
    send("x", 1'b1, "R4 after invalid");
    // R5: back-to-back repeats
    send_str("/cgi-win/cgi-win/cgi-win/cgi-bin", "R5 repeats");
    // R6: two bits on the same cycle
    send_str("/unsafe.cgi", "R6 simultaneous");
    // R7: shared prefix, distinct tails
    send_str("/cgi-bin/cgi-wib/cgi-bwn/cgi-/cgi-win", "R7 shared prefix");
    // R9: near misses
    send_str("/CGI-WIN/scriptZ/insecure.cgj", "R9 near miss");
    send_str("xcgi-bin/Scripts/unsafe.cgI", "R9 near miss");
    // R8: partial before reset does not combine
    send_str("/cgi-", "R8 partial");
    do_reset();
    send_str("win", "R8 after reset");
    send_str("safe.cg", "R8 partial");
    do_reset();
    send_str("i", "R8 after reset");
    // R10: random stream
    run_random();
    for (int i = 0; i < 4; i++) send(8'h00, 1'b0, "R10 flush");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    mon_on = 0;
    done   = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule